// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit resolves true data dependences between neighbouring instructions in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It owns the control half of the decode-to-execute pipeline register: the destination number, the two source numbers, and the valid, writes-register and is-load flags. For the instruction now in execute, it compares each source register number with the destinations of the two older instructions in the memory and writeback stages. It then steers each ALU operand from one of three places: the register-file value read in decode, the ALU result held at the memory stage, or the writeback value (the loaded word or the ALU result).

The register file is split-phase: it writes in the first half of a cycle and reads in the second half. A result in writeback is therefore visible to decode in the same cycle, so no path from writeback to decode is needed. A load cannot give its data to the instruction directly behind it in time. When the decode instruction reads the destination of a load now in execute, the unit holds the program counter and the fetch/decode register for one cycle and loads a bubble into execute. The consumer then picks up the loaded word from the writeback path, one cycle late.

Top module: `hazard_fwd_unit`

## Requirements
- R1: While reset is asserted, the execute-stage control outputs (ex_valid, ex_wen, ex_load) are 0 and hold_front is 0.
- R2: On each clock edge with no stall, the decode fields (id_valid, id_wen, id_load, id_rd) appear on ex_valid, ex_wen, ex_load and ex_rd.
- R3: If the memory-stage instruction is valid, writes a register, and its destination equals a nonzero execute source, that operand equals mem_alu and its select reads 1. Select encoding: 0 means register file, 1 means memory-stage ALU result, 2 means writeback value.
- R4: If only the writeback-stage instruction is valid, writes a register, and its nonzero destination matches, the operand equals wb_data and its select reads 2.
- R5: If both the memory and writeback stages match the same source, the memory stage (the younger result) wins: select 1.
- R6: With no match, the operand equals the register-file value given for it (ex_rf_a or ex_rf_b) and its select reads 0.
- R7: Register 0 never counts as a match, for forwarding or for the interlock.
- R8: A producer that is not valid, or that does not write a register, never counts as a match for forwarding or for the interlock.
- R9: hold_front is 1 in the same cycle that a valid decode instruction uses a source (id_use1 with id_rs1, or id_use2 with id_rs2) equal to the destination of a valid register-writing load in execute.
- R10: After a cycle with hold_front at 1, execute holds a bubble (ex_valid, ex_wen and ex_load all 0) and hold_front is 0. The held instruction enters execute on the following edge. A single load therefore costs exactly one bubble.
- R11: A non-load producer in execute never raises hold_front, and neither does a match on a source whose use flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode instruction valid |
| id_wen | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_rd | input | RW | Decode destination register |
| id_rs1 | input | RW | Decode first source register |
| id_rs2 | input | RW | Decode second source register |
| id_use1 | input | 1 | Decode instruction reads id_rs1 |
| id_use2 | input | 1 | Decode instruction reads id_rs2 |
| ex_rf_a | input | DW | Register-file value for the first execute operand |
| ex_rf_b | input | DW | Register-file value for the second execute operand |
| mem_valid | input | 1 | Memory-stage instruction valid |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | RW | Memory-stage destination |
| mem_alu | input | DW | Memory-stage ALU result |
| wb_valid | input | 1 | Writeback-stage instruction valid |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | RW | Writeback-stage destination |
| wb_data | input | DW | Writeback value (loaded word or ALU result) |
| op_a | output | DW | First ALU operand |
| op_b | output | DW | Second ALU operand |
| sel_a | output | 2 | Source chosen for op_a |
| sel_b | output | 2 | Source chosen for op_b |
| hold_front | output | 1 | Hold the program counter and the fetch/decode register |
| ex_valid | output | 1 | Execute-stage instruction valid |
| ex_wen | output | 1 | Execute-stage instruction writes a register |
| ex_load | output | 1 | Execute-stage instruction is a load |
| ex_rd | output | RW | Execute-stage destination |

## Verification
Operand steering and the load-use interlock can act in the same cycle. The load in execute may itself need a forwarded base operand while the decode instruction behind it waits on the load's destination. The bench sets this up by placing a load whose source matches the memory-stage destination into execute, then presenting a consumer of that load in decode. In that one sample it expects select 1 with op_a equal to mem_alu and also hold_front at 1. On the next edge it expects the bubble.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hfu_idex_ctl.sv
module hfu_idex_ctl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          id_valid,
  input  logic          id_wen,
  input  logic          id_load,
  input  logic [RW-1:0] id_rd,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  output logic          ex_valid,
  output logic          ex_wen,
  output logic          ex_load,
  output logic [RW-1:0] ex_rd,
  output logic [RW-1:0] ex_rs1,
  output logic [RW-1:0] ex_rs2
);
  logic nxt_valid, nxt_wen, nxt_load;
  logic fld_en;

  // Control flags always update; a stall turns them into a bubble.
  always_comb begin
    fld_en    = !stall;
    nxt_valid = stall ? 1'b0 : id_valid;
    nxt_wen   = stall ? 1'b0 : id_wen;
    nxt_load  = stall ? 1'b0 : id_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_wen   <= 1'b0;
      ex_load  <= 1'b0;
      ex_rd    <= '0;
      ex_rs1   <= '0;
      ex_rs2   <= '0;
    end else begin
      ex_valid <= nxt_valid;
      ex_wen   <= nxt_wen;
      ex_load  <= nxt_load;
      if (fld_en) begin
        ex_rd  <= id_rd;
        ex_rs1 <= id_rs1;
        ex_rs2 <= id_rs2;
      end
    end
  end
endmodule

// File: rtl/hfu_fwd_select.sv
module hfu_fwd_select
  import hfu_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [DW-1:0] rf_val,
  input  logic          mem_valid,
  input  logic          mem_wen,
  input  logic [RW-1:0] mem_rd,
  input  logic [DW-1:0] mem_alu,
  input  logic          wb_valid,
  input  logic          wb_wen,
  input  logic [RW-1:0] wb_rd,
  input  logic [DW-1:0] wb_data,
  output fwd_sel_e      sel,
  output logic [DW-1:0] val
);
  logic src_nz, hit_mem, hit_wb;

  always_comb begin
    src_nz  = (src != '0);
    hit_mem = src_nz && mem_valid && mem_wen && (mem_rd == src);
    hit_wb  = src_nz && wb_valid && wb_wen && (wb_rd == src);
    // Younger producer first.
    if (hit_mem) begin
      sel = FWD_MEM;
      val = mem_alu;
    end else if (hit_wb) begin
      sel = FWD_WB;
      val = wb_data;
    end else begin
      sel = FWD_RF;
      val = rf_val;
    end
  end
endmodule

// File: rtl/hfu_loaduse.sv
module hfu_loaduse #(
  parameter int RW = 5
) (
  input  logic          ex_valid,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [RW-1:0] ex_rd,
  input  logic          id_valid,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  output logic          stall
);
  logic ld_live, dep1, dep2;

  always_comb begin
    ld_live = ex_valid && ex_wen && ex_load && (ex_rd != '0);
    dep1    = id_use1 && (id_rs1 == ex_rd);
    dep2    = id_use2 && (id_rs2 == ex_rd);
    stall   = ld_live && id_valid && (dep1 || dep2);
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hfu_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic          id_wen,
  input  logic          id_load,
  input  logic [RW-1:0] id_rd,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [DW-1:0] ex_rf_a,
  input  logic [DW-1:0] ex_rf_b,
  input  logic          mem_valid,
  input  logic          mem_wen,
  input  logic [RW-1:0] mem_rd,
  input  logic [DW-1:0] mem_alu,
  input  logic          wb_valid,
  input  logic          wb_wen,
  input  logic [RW-1:0] wb_rd,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          hold_front,
  output logic          ex_valid,
  output logic          ex_wen,
  output logic          ex_load,
  output logic [RW-1:0] ex_rd
);
  localparam int NOPS = 2;

  logic [RW-1:0] ex_rs1_q, ex_rs2_q;
  logic          stall;
  logic [RW-1:0] op_src [NOPS];
  logic [DW-1:0] op_rf  [NOPS];
  logic [DW-1:0] op_val [NOPS];
  fwd_sel_e      op_sel [NOPS];

  hfu_loaduse #(.RW(RW)) u_lu (
    .ex_valid (ex_valid),
    .ex_wen   (ex_wen),
    .ex_load  (ex_load),
    .ex_rd    (ex_rd),
    .id_valid (id_valid),
    .id_use1  (id_use1),
    .id_use2  (id_use2),
    .id_rs1   (id_rs1),
    .id_rs2   (id_rs2),
    .stall    (stall)
  );

  hfu_idex_ctl #(.RW(RW)) u_idex (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .id_valid (id_valid),
    .id_wen   (id_wen),
    .id_load  (id_load),
    .id_rd    (id_rd),
    .id_rs1   (id_rs1),
    .id_rs2   (id_rs2),
    .ex_valid (ex_valid),
    .ex_wen   (ex_wen),
    .ex_load  (ex_load),
    .ex_rd    (ex_rd),
    .ex_rs1   (ex_rs1_q),
    .ex_rs2   (ex_rs2_q)
  );

  assign op_src[0] = ex_rs1_q;
  assign op_src[1] = ex_rs2_q;
  assign op_rf[0]  = ex_rf_a;
  assign op_rf[1]  = ex_rf_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hfu_fwd_select #(.DW(DW), .RW(RW)) u_sel (
      .src       (op_src[g]),
      .rf_val    (op_rf[g]),
      .mem_valid (mem_valid),
      .mem_wen   (mem_wen),
      .mem_rd    (mem_rd),
      .mem_alu   (mem_alu),
      .wb_valid  (wb_valid),
      .wb_wen    (wb_wen),
      .wb_rd     (wb_rd),
      .wb_data   (wb_data),
      .sel       (op_sel[g]),
      .val       (op_val[g])
    );
  end

  assign op_a       = op_val[0];
  assign op_b       = op_val[1];
  assign sel_a      = op_sel[0];
  assign sel_b      = op_sel[1];
  assign hold_front = stall;
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] ex_rs1_q,
  input logic [RW-1:0] ex_rs2_q,
  input logic          mem_valid,
  input logic          mem_wen,
  input logic [RW-1:0] mem_rd,
  input logic [DW-1:0] mem_alu,
  input logic          wb_valid,
  input logic          wb_wen,
  input logic [DW-1:0] wb_data,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          hold_front,
  input logic          ex_valid,
  input logic          ex_wen,
  input logic          ex_load
);
  p_mem_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'd1) |-> (op_a == mem_alu));
  p_wb_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'd2) |-> (op_b == wb_data && wb_valid && wb_wen));
  p_mem_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_wen && ex_rs1_q != '0 && mem_rd == ex_rs1_q) |-> (sel_a == 2'd1));
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1_q == '0 && ex_rs2_q == '0) |-> (sel_a == 2'd0 && sel_b == 2'd0));
  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |=> (!ex_valid && !ex_wen && !ex_load));
  p_single_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |=> !hold_front);
  p_load_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !hold_front);
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ex_rs1_q   (ex_rs1_q),
  .ex_rs2_q   (ex_rs2_q),
  .mem_valid  (mem_valid),
  .mem_wen    (mem_wen),
  .mem_rd     (mem_rd),
  .mem_alu    (mem_alu),
  .wb_valid   (wb_valid),
  .wb_wen     (wb_wen),
  .wb_data    (wb_data),
  .op_a       (op_a),
  .op_b       (op_b),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .hold_front (hold_front),
  .ex_valid   (ex_valid),
  .ex_wen     (ex_wen),
  .ex_load    (ex_load)
);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam logic [DW-1:0] RF_A = 32'h1111_0001;
  localparam logic [DW-1:0] RF_B = 32'h2222_0002;
  localparam logic [DW-1:0] MEMV = 32'hAAAA_0003;
  localparam logic [DW-1:0] WBV  = 32'hBBBB_0004;

  typedef struct packed {
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] mrd;
    logic       mwen;
    logic       mval;
    logic [4:0] wrd;
    logic       wwen;
    logic       wval;
    logic [1:0] ea;
    logic [1:0] eb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  5'd3,  1'b1, 1'b1, 5'd4,  1'b1, 1'b1, 2'd1, 2'd2}, // R3 R4
    '{5'd5,  5'd5,  5'd5,  1'b1, 1'b1, 5'd5,  1'b1, 1'b1, 2'd1, 2'd1}, // R5
    '{5'd6,  5'd7,  5'd8,  1'b1, 1'b1, 5'd9,  1'b1, 1'b1, 2'd0, 2'd0}, // R6
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 2'd0, 2'd0}, // R7
    '{5'd2,  5'd2,  5'd2,  1'b0, 1'b1, 5'd2,  1'b1, 1'b1, 2'd2, 2'd2}, // R8 no write
    '{5'd2,  5'd3,  5'd2,  1'b1, 1'b0, 5'd3,  1'b1, 1'b0, 2'd0, 2'd0}, // R8 invalid
    '{5'd9,  5'd10, 5'd10, 1'b1, 1'b1, 5'd9,  1'b1, 1'b1, 2'd2, 2'd1}, // R3 R4
    '{5'd31, 5'd1,  5'd1,  1'b1, 1'b1, 5'd31, 1'b1, 1'b1, 2'd2, 2'd1}  // R3 R4
  };

  logic          clk, rst_n;
  logic          id_valid, id_wen, id_load, id_use1, id_use2;
  logic [RW-1:0] id_rd, id_rs1, id_rs2;
  logic [DW-1:0] ex_rf_a, ex_rf_b;
  logic          mem_valid, mem_wen, wb_valid, wb_wen;
  logic [RW-1:0] mem_rd, wb_rd;
  logic [DW-1:0] mem_alu, wb_data;
  logic [DW-1:0] op_a, op_b;
  logic [1:0]    sel_a, sel_b;
  logic          hold_front, ex_valid, ex_wen, ex_load;
  logic [RW-1:0] ex_rd;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  hazard_fwd_unit #(.DW(DW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_wen(id_wen), .id_load(id_load), .id_rd(id_rd),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
    .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd), .mem_alu(mem_alu),
    .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd), .wb_data(wb_data),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b),
    .hold_front(hold_front), .ex_valid(ex_valid), .ex_wen(ex_wen),
    .ex_load(ex_load), .ex_rd(ex_rd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_id(input logic v, input logic w, input logic ld, input logic [RW-1:0] rd,
                        input logic [RW-1:0] s1, input logic u1,
                        input logic [RW-1:0] s2, input logic u2);
    id_valid = v; id_wen = w; id_load = ld; id_rd = rd;
    id_rs1 = s1; id_use1 = u1; id_rs2 = s2; id_use2 = u2;
  endtask

  task automatic quiet_back;
    mem_valid = 0; mem_wen = 0; mem_rd = '0;
    wb_valid = 0; wb_wen = 0; wb_rd = '0;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
    return (s == 2'd1) ? MEMV : (s == 2'd2) ? WBV : rf;
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0;
    set_id(1, 1, 1, 5'd7, 5'd7, 1, 5'd7, 1);
    ex_rf_a = RF_A; ex_rf_b = RF_B; mem_alu = MEMV; wb_data = WBV;
    quiet_back();
    tick(); tick();
    // R1: reset state
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 ex_wen", ex_wen, 0);
    chk("R1 ex_load", ex_load, 0);
    chk("R1 hold_front", hold_front, 0);
    set_id(0, 0, 0, '0, '0, 0, '0, 0);
    @(negedge clk); rst_n = 1;
    tick();

    // R2: capture of decode fields
    set_id(1, 1, 0, 5'd12, 5'd1, 1, 5'd2, 1);
    tick();
    chk("R2 ex_rd", ex_rd, 12);
    chk("R2 ex_valid", ex_valid, 1);
    chk("R2 ex_wen", ex_wen, 1);
    chk("R2 ex_load", ex_load, 0);

    // Vector table: forwarding selection
    for (int i = 0; i < NV; i++) begin
      quiet_back();
      set_id(1, 0, 0, '0, VECS[i].rs1, 1, VECS[i].rs2, 1);
      tick();
      set_id(0, 0, 0, '0, '0, 0, '0, 0);
      mem_rd = VECS[i].mrd; mem_wen = VECS[i].mwen; mem_valid = VECS[i].mval;
      wb_rd = VECS[i].wrd; wb_wen = VECS[i].wwen; wb_valid = VECS[i].wval;
      #1;
      chk($sformatf("R3-R8 vec%0d sel_a", i), sel_a, VECS[i].ea);
      chk($sformatf("R3-R8 vec%0d sel_b", i), sel_b, VECS[i].eb);
      chk($sformatf("R3-R8 vec%0d op_a", i), op_a, pick(VECS[i].ea, RF_A));
      chk($sformatf("R3-R8 vec%0d op_b", i), op_b, pick(VECS[i].eb, RF_B));
    end

    // R9 R10: load in EX (base forwarded from MEM) with dependent in ID
    quiet_back();
    set_id(1, 1, 1, 5'd7, 5'd4, 1, 5'd0, 0);
    tick();
    mem_valid = 1; mem_wen = 1; mem_rd = 5'd4;
    set_id(1, 1, 0, 5'd8, 5'd7, 1, 5'd3, 1);
    #1;
    chk("R9 hold_front on rs1", hold_front, 1);
    chk("R3 load base forwarded during stall sel", sel_a, 2'd1);
    chk("R3 load base forwarded during stall op", op_a, MEMV);
    tick();
    quiet_back();
    #1;
    chk("R10 bubble ex_valid", ex_valid, 0);
    chk("R10 bubble ex_wen", ex_wen, 0);
    chk("R10 bubble ex_load", ex_load, 0);
    chk("R10 single stall", hold_front, 0);
    tick();
    chk("R10 consumer enters ex_valid", ex_valid, 1);
    chk("R10 consumer enters ex_rd", ex_rd, 8);

    // R9 on the second source
    set_id(1, 1, 1, 5'd11, 5'd0, 0, 5'd0, 0);
    tick();
    set_id(1, 0, 0, 5'd0, 5'd1, 1, 5'd11, 1);
    #1;
    chk("R9 hold_front on rs2", hold_front, 1);
    tick();
    set_id(0, 0, 0, '0, '0, 0, '0, 0);
    tick();

    // R7: load to register 0 does not interlock
    set_id(1, 1, 1, 5'd0, 5'd0, 0, 5'd0, 0);
    tick();
    set_id(1, 0, 0, 5'd0, 5'd0, 1, 5'd0, 1);
    #1;
    chk("R7 no stall on reg0", hold_front, 0);

    // R11: non-load producer does not interlock
    set_id(1, 1, 0, 5'd7, 5'd0, 0, 5'd0, 0);
    tick();
    set_id(1, 0, 0, 5'd0, 5'd7, 1, 5'd7, 1);
    #1;
    chk("R11 no stall for ALU producer", hold_front, 0);

    // R11: matching source with use flag clear
    set_id(1, 1, 1, 5'd9, 5'd0, 0, 5'd0, 0);
    tick();
    set_id(1, 0, 0, 5'd0, 5'd9, 0, 5'd9, 0);
    #1;
    chk("R11 no stall for unused source", hold_front, 0);

    // R8: load that does not write a register
    set_id(1, 0, 1, 5'd9, 5'd0, 0, 5'd0, 0);
    tick();
    set_id(1, 0, 0, 5'd0, 5'd9, 1, 5'd0, 0);
    #1;
    chk("R8 no stall non-writing load", hold_front, 0);

    // R8: invalid load in EX
    set_id(0, 1, 1, 5'd9, 5'd0, 0, 5'd0, 0);
    tick();
    set_id(1, 0, 0, 5'd0, 5'd9, 1, 5'd0, 0);
    #1;
    chk("R8 no stall invalid load", hold_front, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule